// File: doc/BRIEF.md
# Conformal Mapping Unit for Drift Circles

This block takes a drift circle, described by the position of its wire (x, y) and its drift radius r, and maps it into conformal space about a chosen reference point (x0, y0). The mapping inverts the circle about that point. The inversion divisor is D = (x − x0)² + (y − y0)² − r². The mapped centre is ((x − x0)/D + x0, (y − y0)/D + y0) and the mapped radius is r/D. A track finder uses it so that circular tracks become straight lines before a line search.

All values are W-bit two's complement fixed point with F fractional bits. The default is 24 bits with 16 of them fractional. The unit is fully pipelined, and it has three radix-2 divider pipelines, one for each of the three numerators, which all share the divisor D. The x0 and y0 offsets, the numerator signs and the error flag travel through a delay line as long as the dividers, so every result is assembled from one and the same input sample.

Both streams use valid/ready. A sample is taken when in_valid and in_ready are both high at a clock edge, and a result leaves when out_valid and out_ready are both high. Back-pressure freezes the whole pipeline. in_ready equals "no result is held, or the result is being taken", which makes it a combinational function of out_ready. A held result stays valid and unchanged until it is taken. Bubbles inside the pipeline do not absorb a stall.

Top module: `conformal_xform`

## Requirements
- R1: D is computed as dx² + dy² − r² with dx = x − x0 and dy = y − y0. When D ≤ 0, out_err is 1 and out_x, out_y and out_r are all 0. Otherwise out_err is 0.
- R2: out_x = q(dx) + x0 and out_y = q(dy) + y0. Here q(n) is n/D carried to F fractional bits, with its magnitude truncated toward zero and the sign of n restored.
- R3: out_r = q(r), with the sign of r kept and no offset added.
- R4: Every input and output is a W-bit two's complement number with F fractional bits, so an integer value k stands for k·2^−F. The defaults are W = 24 and F = 16.
- R5: The magnitude of each quotient is capped at 2^(W−1) − 1 LSB before the offset is added. The sum is then clamped to the range [−2^(W−1), 2^(W−1) − 1].
- R6: While out_ready stays high, a sample accepted at one clock edge shows up with out_valid high W + 3 edges later.
- R7: While out_ready stays high, in_ready stays high and one sample is taken on every cycle, so N back-to-back samples finish in N + W + 3 cycles.
- R8: While out_valid is high and out_ready is low, in_ready is low, and out_valid, out_x, out_y, out_r and out_err keep their values into the next cycle.
- R9: A synchronous reset throws away every sample in flight. After reset, out_valid is 0 and in_ready is 1.
- R10: Results leave in the order the samples were taken, exactly one result for each sample taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Unit can take a sample this cycle |
| in_x | input | W | Wire x position |
| in_y | input | W | Wire y position |
| in_r | input | W | Drift radius |
| in_x0 | input | W | Reference point x |
| in_y0 | input | W | Reference point y |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | W | Mapped centre x |
| out_y | output | W | Mapped centre y |
| out_r | output | W | Mapped radius |
| out_err | output | 1 | D was zero or negative |

## Verification
The bench builds the unit with W = 10 and F = 5. Because 2F ≥ W − 1, a one-LSB difference gives a quotient larger than the W-bit range, so the quotient cap can be reached as well as the clamp after the offset is added. The pipeline depth shrinks to 13, which keeps a sweep of 5184 combinations of position, reference point and radius short enough to run twice: once with a free-running sink, and once with an irregular out_ready and gaps in the input. That sweep includes many cases where D ≤ 0 and many where the sum saturates. Directed samples with hand-computed results pin down the latency, the symmetric quotient cap and the discarding of in-flight samples by reset.

// File: rtl/cft_pkg.sv
package cft_pkg;
  // one divider lane per numerator
  typedef enum logic [1:0] {
    LANE_X = 2'd0,
    LANE_Y = 2'd1,
    LANE_R = 2'd2
  } lane_e;
  localparam int unsigned NUM_LANES = 3;
endpackage

// File: rtl/cft_delay.sv
module cft_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_line
      logic [WIDTH-1:0] taps [DEPTH];
      always_ff @(posedge clk) begin
        if (en) begin
          taps[0] <= d;
          for (int i = 1; i < int'(DEPTH); i++) taps[i] <= taps[i-1];
        end
      end
      assign q = taps[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/cft_div.sv
// Pipelined restoring divider, one quotient bit per stage, MSB first.
module cft_div #(
  parameter int unsigned NMW = 16,
  parameter int unsigned DMW = 16,
  parameter int unsigned QB  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           in_valid,
  input  logic [NMW-1:0] num,
  input  logic [DMW-1:0] den,
  output logic           out_valid,
  output logic [QB-1:0]  quo,
  output logic           out_ovf
);
  localparam int unsigned CW = ((NMW > DMW + QB) ? NMW : DMW + QB) + 1;

  logic [NMW-1:0] st_rem [QB];
  logic [DMW-1:0] st_den [QB];
  logic [QB-1:0]  st_q   [QB];
  logic [QB-1:0]  st_ovf;
  logic [QB-1:0]  st_v;

  logic [NMW-1:0] src_rem [QB];
  logic [DMW-1:0] src_den [QB];
  logic [QB-1:0]  src_q   [QB];
  logic [NMW-1:0] nx_rem  [QB];
  logic [QB-1:0]  nx_q    [QB];

  // quotient would need more than QB bits
  logic head_ovf;
  assign head_ovf = CW'(num) >= (CW'(den) << QB);

  always_comb begin
    src_rem[0] = num;
    src_den[0] = den;
    src_q[0]   = '0;
    for (int i = 1; i < int'(QB); i++) begin
      src_rem[i] = st_rem[i-1];
      src_den[i] = st_den[i-1];
      src_q[i]   = st_q[i-1];
    end
    for (int i = 0; i < int'(QB); i++) begin
      logic [CW-1:0] trial;
      trial = CW'(src_den[i]) << (int'(QB) - 1 - i);
      if (CW'(src_rem[i]) >= trial) begin
        nx_rem[i] = NMW'(CW'(src_rem[i]) - trial);
        nx_q[i]   = src_q[i] | (QB'(1) << (int'(QB) - 1 - i));
      end else begin
        nx_rem[i] = src_rem[i];
        nx_q[i]   = src_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v <= '0;
    end else if (en) begin
      st_v[0] <= in_valid;
      for (int i = 1; i < int'(QB); i++) st_v[i] <= st_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      st_ovf[0] <= head_ovf;
      for (int i = 1; i < int'(QB); i++) st_ovf[i] <= st_ovf[i-1];
      for (int i = 0; i < int'(QB); i++) begin
        st_rem[i] <= nx_rem[i];
        st_den[i] <= src_den[i];
        st_q[i]   <= nx_q[i];
      end
    end
  end

  assign out_valid = st_v[QB-1];
  assign quo       = st_q[QB-1];
  assign out_ovf   = st_ovf[QB-1];

  // R2
  div_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ovf) |-> (CW'(st_rem[QB-1]) < CW'(st_den[QB-1])));
endmodule

// File: rtl/cft_front.sv
// Differences, squares, divisor and numerator magnitudes (three stages).
module cft_front
  import cft_pkg::*;
#(
  parameter int unsigned W = 24,
  parameter int unsigned F = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                en,
  input  logic                                in_valid,
  input  logic signed [W-1:0]                 in_x,
  input  logic signed [W-1:0]                 in_y,
  input  logic signed [W-1:0]                 in_r,
  input  logic signed [W-1:0]                 in_x0,
  input  logic signed [W-1:0]                 in_y0,
  output logic                                out_valid,
  output logic [NUM_LANES-1:0][W+2*F:0]       out_num,
  output logic [NUM_LANES-1:0]                out_neg,
  output logic [2*W+1:0]                      out_den,
  output logic                                out_err,
  output logic signed [W-1:0]                 out_x0,
  output logic signed [W-1:0]                 out_y0
);
  localparam int unsigned DXW  = W + 1;
  localparam int unsigned SQW  = 2 * DXW;
  localparam int unsigned DENW = SQW + 1;

  logic                  v1, v2;
  logic signed [DXW-1:0] d1 [NUM_LANES];
  logic signed [DXW-1:0] d2 [NUM_LANES];
  logic signed [SQW-1:0] sq [NUM_LANES];
  logic signed [W-1:0]   x0_1, y0_1, x0_2, y0_2;
  logic signed [DENW-1:0] dsum;
  logic [DXW-1:0]        mag [NUM_LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end
  end

  always_comb begin
    dsum = DENW'(sq[LANE_X]) + DENW'(sq[LANE_Y]) - DENW'(sq[LANE_R]);
    for (int l = 0; l < int'(NUM_LANES); l++)
      mag[l] = d2[l][DXW-1] ? DXW'(-d2[l]) : DXW'(d2[l]);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      // stage 1: offsets from the reference point
      d1[LANE_X] <= $signed({in_x[W-1], in_x}) - $signed({in_x0[W-1], in_x0});
      d1[LANE_Y] <= $signed({in_y[W-1], in_y}) - $signed({in_y0[W-1], in_y0});
      d1[LANE_R] <= $signed({in_r[W-1], in_r});
      x0_1 <= in_x0;
      y0_1 <= in_y0;
      // stage 2: squares
      for (int l = 0; l < int'(NUM_LANES); l++) begin
        sq[l] <= SQW'(d1[l]) * SQW'(d1[l]);
        d2[l] <= d1[l];
      end
      x0_2 <= x0_1;
      y0_2 <= y0_1;
      // stage 3: divisor, error, scaled magnitudes
      out_err <= (dsum <= 0);
      out_den <= (dsum <= 0) ? (2*W+2)'(1) : dsum[2*W+1:0];
      for (int l = 0; l < int'(NUM_LANES); l++) begin
        out_num[l] <= {mag[l], {(2*F){1'b0}}};
        out_neg[l] <= d2[l][DXW-1];
      end
      out_x0 <= x0_2;
      out_y0 <= y0_2;
    end
  end
endmodule

// File: rtl/conformal_xform.sv
module conformal_xform
  import cft_pkg::*;
#(
  parameter int unsigned W = 24,
  parameter int unsigned F = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic signed [W-1:0] in_r,
  input  logic signed [W-1:0] in_x0,
  input  logic signed [W-1:0] in_y0,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y,
  output logic signed [W-1:0] out_r,
  output logic                out_err
);
  localparam int unsigned NMW = W + 2 * F + 1;
  localparam int unsigned DMW = 2 * W + 2;
  localparam int unsigned QB  = W - 1;
  localparam int unsigned SBW = 2 * W + NUM_LANES + 1;
  localparam logic signed [W:0] SAT_HI = $signed({2'b00, {(W-1){1'b1}}});
  localparam logic signed [W:0] SAT_LO = $signed({2'b11, {(W-1){1'b0}}});

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic                          f_v, f_err;
  logic [NUM_LANES-1:0][NMW-1:0] f_num;
  logic [NUM_LANES-1:0]          f_neg;
  logic [DMW-1:0]                f_den;
  logic signed [W-1:0]           f_x0, f_y0;

  cft_front #(.W(W), .F(F)) u_front (
    .clk(clk), .rst(rst), .en(adv), .in_valid(in_valid),
    .in_x(in_x), .in_y(in_y), .in_r(in_r), .in_x0(in_x0), .in_y0(in_y0),
    .out_valid(f_v), .out_num(f_num), .out_neg(f_neg), .out_den(f_den),
    .out_err(f_err), .out_x0(f_x0), .out_y0(f_y0)
  );

  logic [NUM_LANES-1:0][QB-1:0] dq;
  logic [NUM_LANES-1:0]         dovf, dv;

  generate
    for (genvar l = 0; l < int'(NUM_LANES); l++) begin : g_lane
      cft_div #(.NMW(NMW), .DMW(DMW), .QB(QB)) u_div (
        .clk(clk), .rst(rst), .en(adv), .in_valid(f_v),
        .num(f_num[l]), .den(f_den),
        .out_valid(dv[l]), .quo(dq[l]), .out_ovf(dovf[l])
      );
    end
  endgenerate

  // operands that bypass the dividers, delay-matched to them
  logic [SBW-1:0]       sb_d;
  logic signed [W-1:0]  x0_d, y0_d;
  logic [NUM_LANES-1:0] neg_d;
  logic                 err_d;

  cft_delay #(.WIDTH(SBW), .DEPTH(QB)) u_side (
    .clk(clk), .en(adv), .d({f_x0, f_y0, f_neg, f_err}), .q(sb_d)
  );
  assign {x0_d, y0_d, neg_d, err_d} = sb_d;

  logic signed [W-1:0] res [NUM_LANES];

  always_comb begin
    for (int l = 0; l < int'(NUM_LANES); l++) begin
      logic [QB-1:0]     qm;
      logic signed [W:0] qv, off, sum;
      qm  = dovf[l] ? {QB{1'b1}} : dq[l];
      qv  = neg_d[l] ? -$signed({2'b00, qm}) : $signed({2'b00, qm});
      if (lane_e'(l) == LANE_X)      off = $signed({x0_d[W-1], x0_d});
      else if (lane_e'(l) == LANE_Y) off = $signed({y0_d[W-1], y0_d});
      else                           off = '0;
      sum = qv + off;
      if (err_d)             res[l] = '0;
      else if (sum > SAT_HI) res[l] = SAT_HI[W-1:0];
      else if (sum < SAT_LO) res[l] = SAT_LO[W-1:0];
      else                   res[l] = sum[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= &dv;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_x   <= res[LANE_X];
      out_y   <= res[LANE_Y];
      out_r   <= res[LANE_R];
      out_err <= err_d;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_r) && $stable(out_err)));
  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R1
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_x == '0 && out_y == '0 && out_r == '0));
  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
  // R10
  lanes_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (dv == '0) || (dv == '1));
endmodule

// File: tb/test_conformal_xform.sv
module test_conformal_xform;
  localparam int W = 10;
  localparam int F = 5;
  localparam int LAT = W + 3;
  localparam longint QM = (64'sd1 <<< (W - 1)) - 1;
  localparam int NS = 6 * 6 * 6 * 6 * 4;

  typedef struct { longint x; longint y; longint r; bit e; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_err;
  logic signed [W-1:0] in_x = '0, in_y = '0, in_r = '0, in_x0 = '0, in_y0 = '0;
  logic signed [W-1:0] out_x, out_y, out_r;

  int checks = 0, fails = 0, wd = 0;
  exp_t expq[$];
  int vals[6] = '{-512, -300, -17, 0, 5, 511};
  int rads[4] = '{0, 3, 40, 511};

  always #5 clk = ~clk;

  conformal_xform #(.W(W), .F(F)) i_conformal_xform (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_r(in_r), .in_x0(in_x0), .in_y0(in_y0),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_r(out_r), .out_err(out_err)
  );

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint lane_q(longint n, longint den);
    longint mag, qm;
    mag = (n < 0 ? -n : n) * (64'sd1 <<< (2 * F));
    if (mag >= den * (64'sd1 <<< (W - 1))) qm = QM;
    else qm = mag / den;
    return (n < 0) ? -qm : qm;
  endfunction

  function automatic longint clampw(longint v);
    if (v > QM) return QM;
    if (v < -QM - 1) return -QM - 1;
    return v;
  endfunction

  function automatic exp_t model(longint x, longint y, longint r, longint x0, longint y0);
    exp_t e;
    longint dx, dy, den;
    dx = x - x0; dy = y - y0;
    den = dx * dx + dy * dy - r * r;
    if (den <= 0) begin
      e.x = 0; e.y = 0; e.r = 0; e.e = 1'b1;
    end else begin
      e.x = clampw(lane_q(dx, den) + x0);
      e.y = clampw(lane_q(dy, den) + y0);
      e.r = clampw(lane_q(r, den));
      e.e = 1'b0;
    end
    return e;
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid low in reset", out_valid, 0);
    rst = 1'b0;
  endtask

  // Stream the full sweep; bp selects irregular sink and source gaps
  task automatic run_stream(bit bp);
    int sent = 0, cyc = 0;
    bit held = 0;
    longint hx = 0, hy = 0, hr = 0, he = 0;
    while (sent < NS || expq.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (held) begin
        chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
        chk(out_x == hx && out_y == hy && out_r == hr && out_err == he,
            "R8 data held", out_x, hx);
      end
      out_ready = bp ? ((cyc % 5) < 3) : 1'b1;
      if (sent < NS && !(bp && (cyc % 7) == 0)) begin
        int k = sent;
        in_x  = W'(vals[k % 6]); k = k / 6;
        in_y  = W'(vals[k % 6]); k = k / 6;
        in_x0 = W'(vals[k % 6]); k = k / 6;
        in_y0 = W'(vals[k % 6]); k = k / 6;
        in_r  = W'(rads[k % 4]);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (!bp) chk(in_ready == 1'b1, "R7 ready with free sink", in_ready, 1);
      held = out_valid && !out_ready;
      if (held) begin
        chk(in_ready == 1'b0, "R8 ready low on stall", in_ready, 0);
        hx = out_x; hy = out_y; hr = out_r; he = out_err;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10 unexpected result", 1, 0);
        end else begin
          exp_t e = expq.pop_front();
          chk(out_err == e.e, "R1 error flag", out_err, e.e);
          chk(longint'(out_x) == e.x, "R2 x result", out_x, e.x);
          chk(longint'(out_y) == e.y, "R2 y result", out_y, e.y);
          chk(longint'(out_r) == e.r, "R3 radius result", out_r, e.r);
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(longint'(in_x), longint'(in_y), longint'(in_r),
                             longint'(in_x0), longint'(in_y0)));
        sent++;
      end
      if (cyc > 60000) break;
    end
    in_valid = 1'b0;
    if (!bp) chk(cyc == NS + LAT, "R7 drain cycles", cyc, NS + LAT);
    chk(expq.size() == 0, "R10 all results returned", expq.size(), 0);
  endtask

  // One sample with hand-computed result; optionally checks latency
  task automatic one_shot(int x, int y, int r, int x0, int y0,
                          int ex, int ey, int er, bit ee, string tag, bit lat);
    int cnt = 0;
    @(negedge clk);
    out_ready = 1'b1;
    in_x = W'(x); in_y = W'(y); in_r = W'(r); in_x0 = W'(x0); in_y0 = W'(y0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    if (lat) chk(cnt == LAT, "R6 latency", cnt, LAT);
    chk(out_err == ee, {tag, " err"}, out_err, ee);
    chk(longint'(out_x) == ex, {tag, " x"}, out_x, ex);
    chk(longint'(out_y) == ey, {tag, " y"}, out_y, ey);
    chk(longint'(out_r) == er, {tag, " r"}, out_r, er);
  endtask

  initial begin
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);

    // R4 scaling: dx=2.0, r=1.0, D=3.0 -> 0.666 -> 21/32, plus x0=1.0
    one_shot(96, 10, 32, 32, 10, 53, 10, 10, 1'b0, "R4 scaled", 1'b1);
    // R5 quotient cap, both signs
    one_shot(1, 0, 0, 0, 0, 511, 0, 0, 1'b0, "R5 cap positive", 1'b0);
    one_shot(-1, 0, 0, 0, 0, -511, 0, 0, 1'b0, "R5 cap negative", 1'b0);
    // R5 clamp after offset
    one_shot(501, -500, 0, 500, -500, 511, -500, 0, 1'b0, "R5 offset clamp", 1'b0);
    // R1 zero divisor: 9 + 16 - 25
    one_shot(3, 4, 5, 0, 0, 0, 0, 0, 1'b1, "R1 zero divisor", 1'b0);

    run_stream(1'b0);
    run_stream(1'b1);

    // R9 reset discards samples in flight
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      in_x = W'(i * 7); in_y = W'(3); in_r = '0; in_x0 = '0; in_y0 = '0;
      in_valid = 1'b1;
    end
    do_reset();
    in_valid = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 3 * LAT; i++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      chk(seen == 0, "R9 in-flight discarded", seen, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule